// File: doc/BRIEF.md
# Per-Bit Access-Policy Control Register

This block is a single control/status register of parameterized width in which every bit has its own software access policy. The policy of each bit is a 4-bit code taken from a vector parameter fixed at elaboration. One register can therefore hold plain configuration bits, event flags that software acknowledges, request bits that hardware retires, bits that always read as zero, and bits whose state changes when they are read.

Software reaches the register through a minimal bus-side port: a select, a read strobe, a write strobe, write data and combinational read data. Logic on the hardware side drives per-bit set, clear and live-value inputs and observes the current bit values on `q`. Read data always shows the bit values from before any read side effect. The side effect itself takes place on the clock edge that ends the read cycle. When a hardware event and a software action hit the same bit in the same cycle, the priority is fixed so that no event is lost.

Top module: `policy_csr`

## Requirements
- R1: On reset every bit that holds state loads its value from `RESET_VAL`.
- R2: A policy-0 (read-only) bit reads and drives `q` from `hw_val`, and software writes have no effect on it.
- R3: A policy-1 (read-write) bit or policy-5 (reserved, preserved) bit takes `wr_data` on a write and otherwise holds its value. Reads return that value.
- R4: A policy-2 bit clears when software writes 1, ignores a write of 0, and sets on `hw_set`. When `hw_set` and a clearing write arrive together, the set wins.
- R5: A policy-3 bit clears when software writes 0, ignores a write of 1, and sets on `hw_set`. When `hw_set` and a clearing write arrive together, the set wins.
- R6: A policy-4 bit sets when software writes 1, ignores a write of 0, and clears on `hw_clr`. When `hw_clr` and a setting write arrive together, the write wins.
- R7: A policy-6 (reserved, zero) bit and a policy-7 (write-only) bit always read 0. A policy-7 bit keeps no state, and its `q` pulses high only during a cycle that writes 1 to it.
- R8: A policy-8 bit ignores writes, sets on `hw_set`, and returns its value on a read before clearing at the next edge. When `hw_set` arrives during a read, the set wins.
- R9: A policy-9 bit becomes 1 after any read and clears on a software write of 1. If a read and a write of 1 arrive in the same cycle, the clear wins.
- R10: A policy-10 bit takes `wr_data` on a write and clears after a read. If a read and a write arrive in the same cycle, the write wins.
- R11: While `sel` is low, `rd_en` and `wr_en` have no effect on any bit.
- R12: Policy codes 11 to 15 behave as policy 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register selected by the bus |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Read data, showing values from before any read side effect |
| hw_set | input | WIDTH | Per-bit hardware set |
| hw_clr | input | WIDTH | Per-bit hardware clear |
| hw_val | input | WIDTH | Live value for read-only bits |
| q | output | WIDTH | Current bit values toward hardware |

## Verification
The bench builds the register 12 bits wide. Bits 0 to 10 carry policy codes 0 to 10 in order, and bit 11 carries code 15. `RESET_VAL` is 12'hB6D, which holds a mix of ones and zeros across the policies. With this setup, every policy, its priority cases and the handling of an unused code are all active in the same cycles. Random traffic therefore lands reads, writes, hardware sets and clears, and a low select on every kind of bit at once.

// File: rtl/policy_csr.sv
module policy_csr #(
  parameter int WIDTH = 8,
  parameter logic [4*WIDTH-1:0] POLICY = {WIDTH{4'd1}},
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] hw_clr,
  input  logic [WIDTH-1:0] hw_val,
  output logic [WIDTH-1:0] q
);
  logic rd, wr;
  logic [WIDTH-1:0] st, st_nx;

  assign rd = sel & rd_en;
  assign wr = sel & wr_en;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam logic [3:0] P = POLICY[4*i +: 4];
    logic wd, w1, w0, nx, rv, qv;
    assign wd = wr_data[i];
    assign w1 = wr & wd;
    assign w0 = wr & ~wd;

    always_comb begin
      nx = st[i];
      rv = st[i];
      qv = st[i];
      case (P)
        4'd0: begin rv = hw_val[i]; qv = hw_val[i]; end
        4'd1, 4'd5: nx = wr ? wd : st[i];
        4'd2: nx = hw_set[i] | (st[i] & ~w1);
        4'd3: nx = hw_set[i] | (st[i] & ~w0);
        4'd4: nx = w1 | (st[i] & ~hw_clr[i]);
        4'd7: begin nx = 1'b0; rv = 1'b0; qv = w1; end
        4'd8: nx = hw_set[i] | (st[i] & ~rd);
        4'd9: nx = (st[i] | rd) & ~w1;
        4'd10: nx = wr ? wd : (rd ? 1'b0 : st[i]);
        default: begin rv = 1'b0; qv = 1'b0; end
      endcase
    end

    assign st_nx[i]   = nx;
    assign rd_data[i] = rv;
    assign q[i]       = qv;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= RESET_VAL;
    else        st <= st_nx;
  end
endmodule

module policy_csr_chk #(
  parameter int WIDTH = 8,
  parameter logic [4*WIDTH-1:0] POLICY = {WIDTH{4'd1}}
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             rd_en,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] hw_set,
  input logic [WIDTH-1:0] hw_val,
  input logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_chk
    localparam logic [3:0] P = POLICY[4*i +: 4];
    if (P == 4'd0) begin : g_ro
      // R2
      ro_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[i] == hw_val[i]);
    end
    if (P == 4'd1) begin : g_rw
      // R3
      rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en) |=> $stable(q[i]));
    end
    if (P == 4'd2) begin : g_w1c
      // R4
      w1c_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[i] |=> q[i]);
    end
    if (P == 4'd6 || P == 4'd7) begin : g_zero
      // R7
      reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[i]);
    end
    if (P == 4'd8) begin : g_rc
      // R8
      rc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && !hw_set[i]) |=> !q[i]);
    end
    if (P == 4'd9) begin : g_rs
      // R9
      rs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_en && !(wr_en && wr_data[i])) |=> q[i]);
    end
    if (P == 4'd10) begin : g_rcw
      // R10
      rcw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr_en) |=> q[i] == $past(wr_data[i]));
    end
  end
endmodule

bind policy_csr policy_csr_chk #(.WIDTH(WIDTH), .POLICY(POLICY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .hw_set(hw_set), .hw_val(hw_val), .q(q)
);

// File: tb/policy_csr_tb.sv
`timescale 1ns/1ps
module policy_csr_tb;
  localparam int W = 12;
  localparam logic [4*W-1:0] POL = {4'd15, 4'd10, 4'd9, 4'd8, 4'd7, 4'd6,
                                     4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0};
  localparam logic [W-1:0] RV = 12'hB6D;

  logic clk = 0, rst_n = 0, sel = 0, rd_en = 0, wr_en = 0;
  logic [W-1:0] wr_data = '0, hw_set = '0, hw_clr = '0, hw_val = '0;
  logic [W-1:0] rd_data, q;
  logic [W-1:0] ms;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  policy_csr #(.WIDTH(W), .POLICY(POL), .RESET_VAL(RV)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .hw_set(hw_set), .hw_clr(hw_clr),
    .hw_val(hw_val), .q(q));

  function automatic string req_of(int b);
    case (b)
      0: return "R2";   1: return "R3";   2: return "R4";  3: return "R5";
      4: return "R6";   5: return "R3";   6: return "R7";  7: return "R7";
      8: return "R8";   9: return "R9";  10: return "R10";
      default: return "R12";
    endcase
  endfunction

  // Behavioural reference: bit b has policy code b (bit 11 is unused code)
  function automatic logic next_bit(int b, logic s);
    logic r, w, d;
    r = sel && rd_en; w = sel && wr_en; d = wr_data[b];
    if (b == 1 || b == 5) return w ? d : s;
    if (b == 2) return hw_set[b] ? 1'b1 : ((w && d) ? 1'b0 : s);
    if (b == 3) return hw_set[b] ? 1'b1 : ((w && !d) ? 1'b0 : s);
    if (b == 4) return (w && d) ? 1'b1 : (hw_clr[b] ? 1'b0 : s);
    if (b == 8) return hw_set[b] ? 1'b1 : (r ? 1'b0 : s);
    if (b == 9) return (w && d) ? 1'b0 : (r ? 1'b1 : s);
    if (b == 10) return w ? d : (r ? 1'b0 : s);
    return s;
  endfunction

  function automatic logic exp_rd(int b);
    if (b == 0) return hw_val[b];
    if (b == 6 || b == 7 || b == 11) return 1'b0;
    return ms[b];
  endfunction

  function automatic logic exp_q(int b);
    if (b == 7) return sel && wr_en && wr_data[b];
    return exp_rd(b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) ms <= RV;
    else for (int b = 0; b < W; b++) ms[b] <= next_bit(b, ms[b]);
  end

  task automatic compare();
    for (int b = 0; b < W; b++) begin
      checks++;
      if (rd_data[b] !== exp_rd(b)) begin
        errors++;
        $display("FAIL %s rd_data[%0d] actual %b expected %b", req_of(b), b, rd_data[b], exp_rd(b));
      end
      checks++;
      if (q[b] !== exp_q(b)) begin
        errors++;
        $display("FAIL %s q[%0d] actual %b expected %b", req_of(b), b, q[b], exp_q(b));
      end
    end
  endtask

  task automatic step(input logic s, input logic r, input logic w, input logic [W-1:0] d,
                      input logic [W-1:0] hs, input logic [W-1:0] hc, input logic [W-1:0] hv);
    @(negedge clk);
    compare();
    sel = s; rd_en = r; wr_en = w; wr_data = d; hw_set = hs; hw_clr = hc; hw_val = hv;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset values on stateful bits
    checks++;
    if ((rd_data & 12'h73E) !== (RV & 12'h73E)) begin
      errors++;
      $display("FAIL R1 rd_data actual %h expected %h", rd_data & 12'h73E, RV & 12'h73E);
    end
    compare();
    // R4 R5 R8: hardware set beats software clear / read in the same cycle
    step(1, 1, 1, 12'h100 | 12'h004, 12'h10C, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    checks++;
    if (q[2] !== 1'b1 || q[3] !== 1'b1 || q[8] !== 1'b1) begin
      errors++;
      $display("FAIL R4 R5 R8 set-wins actual %b%b%b expected 111", q[8], q[3], q[2]);
    end
    // R6: write-1 set beats hardware clear
    step(1, 0, 1, 12'h010, 0, 12'h010, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    checks++;
    if (q[4] !== 1'b1) begin errors++; $display("FAIL R6 q[4] actual %b expected 1", q[4]); end
    // R9 R10: read and write together
    step(1, 1, 1, 12'h600, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    checks++;
    if (q[9] !== 1'b0 || q[10] !== 1'b1) begin
      errors++;
      $display("FAIL R9 R10 actual %b%b expected 10", q[10], q[9]);
    end
    // R11: strobes without select leave stored bits untouched
    keep = q;
    step(0, 1, 1, ~q, 0, 0, 12'hFFF);
    step(0, 0, 0, 0, 0, 0, 0);
    checks++;
    if ((q & 12'h73E) !== (keep & 12'h73E)) begin
      errors++;
      $display("FAIL R11 q actual %h expected %h", q & 12'h73E, keep & 12'h73E);
    end
    // R2 R7 R12 and all policies under random traffic
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, $urandom % 2, $urandom % 2, W'($urandom),
           W'($urandom) & W'($urandom), W'($urandom) & W'($urandom), W'($urandom));
    step(0, 0, 0, 0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule